// File: doc/BRIEF.md
# Periodic Tick Timer

This block is a down-counting interval timer meant to give an operating system a steady heartbeat, for example one tick per millisecond. Software sets an interval value and turns the timer on. The counter then steps down to zero, refills itself from the interval value, and at each arrival at zero it raises a status flag and, if allowed, a one-cycle interrupt pulse. The period in steps is the interval value plus one.

A per-step enable selects what drives the counter. It can advance on every core clock, or only on cycles where a slower external reference strobe is high. Four 32-bit word registers are reached through a plain single-cycle port. In a write cycle, select and write are high together and the data is taken at the clock edge. In a read cycle, select is high and write is low, and the read data is combinational from the address in that same cycle. Side effects of a read take hold at the clock edge that ends the access.

Top module: `tick_timer_top`

## Requirements
- R1: After reset, the control word, the interval register and the counter register all read zero, and `tick_irq` is low.
- R2: The counter drops by exactly one on each step. A step is a cycle in which enable (control bit 0) is 1 and the source select (control bit 2) is 1. In that mode every clock is a step.
- R3: When the source select bit is 0, a step happens only in cycles where enable is 1 and `ref_tick` is high. In all other cycles the counter keeps its value.
- R4: On a step while the counter is zero, the counter loads the interval register. The interval register is at offset 0x14 and holds 24 bits; its upper bits read zero. As a result, ticks recur every interval+1 steps.
- R5: With an interval of zero, the counter stays at zero. No flag is raised and no pulse is issued.
- R6: The counter going from 1 to 0 on a step sets the count flag, which is control bit 16. A read of the control word at offset 0x10 returns the flag and clears it at the end of the read cycle. If a new 1→0 transition happens in that same cycle, the flag is set again.
- R7: `tick_irq` is high for exactly the one cycle in which the counter reads zero after a 1→0 transition, and only if the interrupt-enable bit (control bit 1) was 1 when the transition happened. Otherwise `tick_irq` stays low.
- R8: A write of any data to the counter register at offset 0x18 sets the counter to zero and clears the count flag. It issues no pulse.
- R9: The control word stores bits 0, 1 and 2 from a write. Every other bit of it reads zero, except the flag in bit 16.
- R10: The calibration word at offset 0x1C always reads the `CALIB_VALUE` parameter, and writes to it change nothing. Any address outside the four words reads zero.
- R11: With enable at 0, the counter holds its value regardless of `ref_tick`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| ref_tick | input | 1 | External reference step strobe |
| tick_irq | output | 1 | One-cycle tick interrupt pulse |

## Verification
The hardest case to reach is a read of the control word landing in the exact cycle of a 1→0 transition. In that cycle the read returns the old flag, and the flag must survive the clear. The stimulus reaches this case by setting a short interval and then reading the control word on every cycle for several periods, so each phase of the period meets a read. A second delicate case is a counter-register write at the moment of a transition, which must suppress both the flag and the pulse; back-to-back counter writes during a running count cover it. A cycle-level reference model in the bench follows every access and strobe, and it compares the interrupt output on every clock.

// File: rtl/tick_pkg.sv
package tick_pkg;
   // Word offsets of the register map
   localparam int unsigned OFF_CTRL   = 32'h10;
   localparam int unsigned OFF_RELOAD = 32'h14;
   localparam int unsigned OFF_COUNT  = 32'h18;
   localparam int unsigned OFF_CALIB  = 32'h1C;

   // Bit positions inside the control word
   localparam int unsigned BIT_ENABLE = 0;
   localparam int unsigned BIT_IRQEN  = 1;
   localparam int unsigned BIT_SRC    = 2;
   localparam int unsigned BIT_FLAG   = 16;

   typedef struct packed {
      logic src_core;
      logic irq_en;
      logic enable;
   } tick_ctrl_t;
endpackage

// File: rtl/tick_regfile.sv
module tick_regfile
   import tick_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned CNT_W  = 24,
   parameter int unsigned ADDR_W = 8,
   parameter logic [DATA_W-1:0] CALIB_VALUE = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel_i,
   input  logic              wr_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [CNT_W-1:0]  cnt_i,
   input  logic              flag_i,
   output logic [DATA_W-1:0] rdata_o,
   output tick_ctrl_t        ctrl_o,
   output logic [CNT_W-1:0]  reload_o,
   output logic              clr_count_o,
   output logic              rd_ctrl_o
);
   localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFF_CTRL);
   localparam logic [ADDR_W-1:0] A_RELOAD = ADDR_W'(OFF_RELOAD);
   localparam logic [ADDR_W-1:0] A_COUNT  = ADDR_W'(OFF_COUNT);
   localparam logic [ADDR_W-1:0] A_CALIB  = ADDR_W'(OFF_CALIB);

   logic [DATA_W-1:0] cnt_word, reload_word, ctrl_word;
   logic              wr_ctrl, wr_reload;

   generate
      if (DATA_W > CNT_W) begin : g_pad
         logic unused_wdata_hi;
         assign cnt_word    = {{(DATA_W-CNT_W){1'b0}}, cnt_i};
         assign reload_word = {{(DATA_W-CNT_W){1'b0}}, reload_o};
         assign unused_wdata_hi = ^wdata_i[DATA_W-1:CNT_W];
      end else begin : g_full
         assign cnt_word    = cnt_i;
         assign reload_word = reload_o;
      end
   endgenerate

   assign wr_ctrl     = sel_i &&  wr_i && (addr_i == A_CTRL);
   assign wr_reload   = sel_i &&  wr_i && (addr_i == A_RELOAD);
   assign clr_count_o = sel_i &&  wr_i && (addr_i == A_COUNT);
   assign rd_ctrl_o   = sel_i && !wr_i && (addr_i == A_CTRL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_o   <= '0;
         reload_o <= '0;
      end else begin
         if (wr_ctrl) begin
            ctrl_o.enable   <= wdata_i[BIT_ENABLE];
            ctrl_o.irq_en   <= wdata_i[BIT_IRQEN];
            ctrl_o.src_core <= wdata_i[BIT_SRC];
         end
         if (wr_reload)
            reload_o <= wdata_i[CNT_W-1:0];
      end
   end

   always_comb begin
      ctrl_word = '0;
      ctrl_word[BIT_ENABLE] = ctrl_o.enable;
      ctrl_word[BIT_IRQEN]  = ctrl_o.irq_en;
      ctrl_word[BIT_SRC]    = ctrl_o.src_core;
      ctrl_word[BIT_FLAG]   = flag_i;
   end

   always_comb begin
      if (addr_i == A_CTRL)        rdata_o = ctrl_word;
      else if (addr_i == A_RELOAD) rdata_o = reload_word;
      else if (addr_i == A_COUNT)  rdata_o = cnt_word;
      else if (addr_i == A_CALIB)  rdata_o = CALIB_VALUE;
      else                         rdata_o = '0;
   end

   // R10: the calibration word never depends on any access history
   always_comb begin
      if (rst_n && addr_i == A_CALIB)
         p_calib_const_r10: assert (rdata_o == CALIB_VALUE);
   end

   // R9: a control write stores exactly the three mode bits
   p_ctrl_store_r9: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ctrl |=> ctrl_o == {$past(wdata_i[BIT_SRC]), $past(wdata_i[BIT_IRQEN]),
                             $past(wdata_i[BIT_ENABLE])});
endmodule

// File: rtl/tick_counter.sv
module tick_counter #(
   parameter int unsigned CNT_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable_i,
   input  logic             src_core_i,
   input  logic             ref_tick_i,
   input  logic             clr_i,
   input  logic [CNT_W-1:0] reload_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             wrap_o
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic step;

   assign step   = enable_i && (src_core_i || ref_tick_i);
   assign wrap_o = step && !clr_i && (cnt_o == ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_o <= '0;
      else if (clr_i)
         cnt_o <= '0;
      else if (step) begin
         if (cnt_o == '0) cnt_o <= reload_i;
         else             cnt_o <= cnt_o - ONE;
      end
   end

   p_dec_by_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !clr_i && cnt_o != '0) |=> cnt_o == $past(cnt_o) - ONE);

   p_ref_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!src_core_i && !ref_tick_i && !clr_i) |=> $stable(cnt_o));

   p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !clr_i && cnt_o == '0) |=> cnt_o == $past(reload_i));

   p_idle_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (reload_i == '0 && cnt_o == '0) |=> cnt_o == '0);

   p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> cnt_o == '0);

   p_hold_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!enable_i && !clr_i) |=> $stable(cnt_o));
endmodule

// File: rtl/tick_flag.sv
module tick_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic wrap_i,
   input  logic irq_en_i,
   input  logic rd_clr_i,
   input  logic wr_clr_i,
   output logic flag_o,
   output logic irq_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_o <= 1'b0;
         irq_o  <= 1'b0;
      end else begin
         irq_o <= wrap_i && irq_en_i;
         if (wr_clr_i)      flag_o <= 1'b0;
         else if (wrap_i)   flag_o <= 1'b1;
         else if (rd_clr_i) flag_o <= 1'b0;
      end
   end

   p_flag_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wrap_i |=> flag_o);

   p_flag_read_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_clr_i && !wrap_i) |=> !flag_o);

   p_irq_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |=> !irq_o);

   p_irq_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wrap_i && irq_en_i) |=> irq_o);

   p_irq_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_en_i |=> !irq_o);

   p_write_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_clr_i |=> !flag_o && !irq_o);
endmodule

// File: rtl/tick_timer_top.sv
module tick_timer_top
   import tick_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned CNT_W  = 24,
   parameter int unsigned ADDR_W = 8,
   parameter logic [DATA_W-1:0] CALIB_VALUE = 32'h4000_2710
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              ref_tick,
   output logic              tick_irq
);
   generate
      if (CNT_W < 2 || CNT_W > DATA_W) begin : g_bad_cnt
         $error("tick_timer_top: CNT_W must lie in 2..DATA_W");
      end
      if (DATA_W <= BIT_FLAG) begin : g_bad_data
         $error("tick_timer_top: DATA_W too narrow for the flag bit");
      end
      if (ADDR_W < 5) begin : g_bad_addr
         $error("tick_timer_top: ADDR_W cannot reach the register map");
      end
   endgenerate

   tick_ctrl_t       ctrl;
   logic [CNT_W-1:0] reload, cnt;
   logic             clr_count, rd_ctrl, wrap, flag;

   tick_regfile #(
      .DATA_W(DATA_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .CALIB_VALUE(CALIB_VALUE)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .sel_i(bus_sel), .wr_i(bus_wr), .addr_i(bus_addr),
      .wdata_i(bus_wdata), .cnt_i(cnt), .flag_i(flag), .rdata_o(bus_rdata),
      .ctrl_o(ctrl), .reload_o(reload), .clr_count_o(clr_count), .rd_ctrl_o(rd_ctrl)
   );

   tick_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .enable_i(ctrl.enable), .src_core_i(ctrl.src_core),
      .ref_tick_i(ref_tick), .clr_i(clr_count), .reload_i(reload),
      .cnt_o(cnt), .wrap_o(wrap)
   );

   tick_flag u_flag (
      .clk(clk), .rst_n(rst_n), .wrap_i(wrap), .irq_en_i(ctrl.irq_en),
      .rd_clr_i(rd_ctrl), .wr_clr_i(clr_count), .flag_o(flag), .irq_o(tick_irq)
   );

   // R7: a pulse always coincides with a counter that has just reached zero
   p_irq_at_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      tick_irq |-> (cnt == '0 || $past(clr_count) == 1'b0) && flag);
endmodule

// File: tb/sim_tick_timer_top.sv
`timescale 1ns/1ps
module sim_tick_timer_top;
   localparam logic [31:0] CAL = 32'h1234_5678;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sel = 1'b0, wr = 1'b0, rt = 1'b0;
   logic [7:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        irq;

   always #2.5 clk = ~clk;

   tick_timer_top #(.CALIB_VALUE(CAL)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_wr(wr), .bus_addr(addr),
      .bus_wdata(wdata), .bus_rdata(rdata), .ref_tick(rt), .tick_irq(irq)
   );

   int vectors = 0;
   int miscompares = 0;
   bit done = 1'b0;

   // reference model state
   int unsigned m_cnt = 0, m_reload = 0;
   bit m_en = 0, m_int = 0, m_src = 0, m_flag = 0, m_irq = 0;

   function automatic logic [31:0] model_read(logic [7:0] a);
      case (a)
         8'h10:   return (32'(m_flag) << 16) | (32'(m_src) << 2) | (32'(m_int) << 1) | 32'(m_en);
         8'h14:   return m_reload;
         8'h18:   return m_cnt;
         8'h1C:   return CAL;
         default: return 32'h0;
      endcase
   endfunction

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic cyc(string tag, bit s, bit w, logic [7:0] a, logic [31:0] d, bit r);
      bit step, clr, wrap, rd_ctrl;
      int unsigned n_cnt;
      sel = s; wr = w; addr = a; wdata = d; rt = r;
      #1;
      if (s && !w) check(tag, rdata, model_read(a));
      step    = m_en && (m_src || r);
      clr     = s && w && a == 8'h18;
      rd_ctrl = s && !w && a == 8'h10;
      wrap    = !clr && step && m_cnt == 1;
      n_cnt   = clr ? 0 : (step ? (m_cnt == 0 ? m_reload : m_cnt - 1) : m_cnt);
      @(posedge clk);
      m_irq = wrap && m_int;
      if (clr)          m_flag = 0;
      else if (wrap)    m_flag = 1;
      else if (rd_ctrl) m_flag = 0;
      m_cnt = n_cnt;
      if (s && w && a == 8'h10) begin m_en = d[0]; m_int = d[1]; m_src = d[2]; end
      if (s && w && a == 8'h14) m_reload = d[23:0];
      #1;
      check({tag, " R7 irq"}, {31'b0, irq}, {31'b0, m_irq});
      @(negedge clk);
      sel = 0; wr = 0; rt = 0;
   endtask

   task automatic wreg(string tag, logic [7:0] a, logic [31:0] d);
      cyc(tag, 1, 1, a, d, 0);
   endtask

   task automatic rreg(string tag, logic [7:0] a);
      cyc(tag, 1, 0, a, 0, 0);
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
   endtask

   initial begin
      #(5.0 * 200000);
      if (!done) begin
         miscompares++;
         $display("FAIL watchdog: actual hung expected finished");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1: reset state
      check("R1 irq", {31'b0, irq}, 32'h0);
      rreg("R1 ctrl", 8'h10);
      rreg("R1 reload", 8'h14);
      rreg("R1 count", 8'h18);
      rreg("R10 calib", 8'h1C);

      // R2 R4: core clock source, interval 3
      wreg("R4 set", 8'h14, 32'd3);
      wreg("R2 ctrl", 8'h10, 32'h7);
      for (int i = 0; i < 14; i++) rreg("R2 R4 count", 8'h18);
      // R6: flag set then cleared by read
      rreg("R6 flag", 8'h10);
      rreg("R6 cleared", 8'h10);

      // R6: reads of the control word at every phase, short interval
      wreg("R6 set", 8'h14, 32'd2);
      for (int i = 0; i < 12; i++) rreg("R6 same-cycle", 8'h10);

      // R4 edge: interval 1
      wreg("R4 set", 8'h14, 32'd1);
      for (int i = 0; i < 8; i++) rreg("R4 one", 8'h18);

      // R3: reference strobe source
      wreg("R3 set", 8'h14, 32'd4);
      wreg("R3 ctrl", 8'h10, 32'h3);
      for (int i = 0; i < 24; i++) cyc("R3 count", 1, 0, 8'h18, 0, (i % 3) == 0);

      // R7: pulses masked
      wreg("R7 ctrl", 8'h10, 32'h5);
      for (int i = 0; i < 12; i++) cyc("R7 masked", 0, 0, 8'h00, 0, 0);
      rreg("R6 flag while masked", 8'h10);

      // R8: counter writes during a run, including back to back
      wreg("R8 ctrl", 8'h10, 32'h7);
      for (int i = 0; i < 3; i++) rreg("R8 pre", 8'h18);
      wreg("R8 clear", 8'h18, 32'hFFFF_FFFF);
      rreg("R8 count", 8'h18);
      for (int i = 0; i < 10; i++) begin
         if (i % 2 == 0) wreg("R8 clear", 8'h18, 32'h0000_0001);
         else            rreg("R8 flag", 8'h10);
      end
      for (int i = 0; i < 4; i++) rreg("R8 run", 8'h18);
      wreg("R8 clear", 8'h18, 32'h0);
      rreg("R8 flag gone", 8'h10);

      // R5: interval zero stays idle
      wreg("R5 set", 8'h14, 32'd0);
      wreg("R5 clear", 8'h18, 32'd0);
      for (int i = 0; i < 16; i++) rreg("R5 idle", 8'h18);
      rreg("R5 no flag", 8'h10);

      // R11: disabled counter holds
      wreg("R11 set", 8'h14, 32'd9);
      for (int i = 0; i < 4; i++) rreg("R11 run", 8'h18);
      wreg("R11 off", 8'h10, 32'h0);
      for (int i = 0; i < 8; i++) cyc("R11 hold", 1, 0, 8'h18, 0, 1);

      // R9 R10: field widths, read-only and unmapped words
      wreg("R9 ctrl", 8'h10, 32'hFFFF_FFF8);
      rreg("R9 ctrl", 8'h10);
      wreg("R9 ctrl", 8'h10, 32'hFFFF_FFFF);
      rreg("R9 ctrl", 8'h10);
      wreg("R9 off", 8'h10, 32'h0);
      wreg("R4 width", 8'h14, 32'hFFFF_FFFF);
      rreg("R4 width", 8'h14);
      wreg("R10 calib wr", 8'h1C, 32'h0);
      rreg("R10 calib", 8'h1C);
      rreg("R9 reload kept", 8'h14);
      rreg("R10 unmapped", 8'h00);
      rreg("R10 unmapped", 8'h20);

      done = 1'b1;
      summary();
      $finish;
   end
endmodule